// File: doc/BRIEF.md
# Interrupt Pin to MSI Message Formatter

This block sits between a set of interrupt input pins and the fabric that delivers message-signalled interrupts. When a pin asks for service, the block looks up that pin's 64-bit redirection entry through a combinational table port. Entries it cannot deliver are discarded. Every other entry is re-packed into one MSI write, made of a 32-bit address and a 32-bit data word.

A request is a single-cycle pulse that carries a 5-bit pin index. The table is read in that same cycle and the formatted message is registered. The message is then held on the output with valid high until the consumer raises ready. While one message waits, one further message can be parked in a holding slot. A request that arrives with both slots occupied is lost, and the block reports this with a one-cycle overflow pulse.

Top module: `irq_msi_fmt`

## Requirements
- R1: A request whose pin index is 24 or larger produces no message and no overflow, whatever the table port returns.
- R2: An entry with its mask bit (bit 16) set produces no message.
- R3: An entry with logical destination mode (bit 11 = 1) produces no message.
- R4: An entry with level trigger mode (bit 15 = 1) produces no message.
- R5: The message address equals 0xFEE00000, with the entry's destination ID (bits 63:56) placed in address bits 19:12 and its 7-bit extended destination (bits 55:49) placed in address bits 11:5. All other address bits are zero.
- R6: The message data holds the vector (entry bits 7:0) in bits 7:0 and the 3-bit delivery mode (entry bits 10:8) in bits 10:8. Bit 11, the level-assert bit 14 and the trigger bit 15 are zero for every delivered message, and bits 31:16 and 13:12 are zero.
- R7: A deliverable request made while the output is empty appears on the output with valid high on the next clock edge.
- R8: While valid is high and ready is low, valid, address and data stay unchanged.
- R9: A deliverable request made while a message waits goes into a one-deep holding slot. It is presented after the waiting message is accepted, so messages keep the order of their requests.
- R10: A deliverable request made when both the output and the holding slot are occupied, and the output is not accepted in that cycle, is dropped. The overflow output is then high for exactly one cycle, on the next edge.
- R11: After reset, valid and overflow are low.
- R12: Pin 4 with vector 0x24, destination 2, physical mode, edge trigger and fixed delivery yields address 0xFEE02000 and data 0x00000024.
- R13: The table index output equals the request pin index in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle service request |
| req_pin | input | 5 | Pin index of the request |
| tbl_pin | output | 5 | Index presented to the redirection table |
| tbl_entry | input | 64 | Redirection entry returned for tbl_pin |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_addr | output | 32 | MSI address |
| msg_data | output | 32 | MSI data |
| ovf | output | 1 | One-cycle pulse when a message was dropped |

## Verification
If the output slot or the holding slot held the wrong state, the error would show at the ports within one cycle. It appears as valid rising or falling at the wrong edge, as a stalled message changing before ready, or as messages arriving out of request order. Overflow bookkeeping that lost count would give an overflow pulse at the wrong edge, or a missing third message after a burst. The bench keeps its own two-entry queue and compares valid, address, data, overflow and the table index on every cycle, so any such divergence is caught on the cycle it appears.

// File: rtl/msi_fmt_pkg.sv
package msi_fmt_pkg;
  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] data;
  } msi_msg_t;

  localparam int BIT_DMODE = 11;
  localparam int BIT_TRIG  = 15;
  localparam int BIT_MASK  = 16;
endpackage

// File: rtl/msi_entry_decode.sv
module msi_entry_decode
  import msi_fmt_pkg::*;
#(
  parameter int          NUM_PINS = 24,
  parameter int          PIN_W    = 5,
  parameter logic [31:0] MSI_BASE = 32'hFEE0_0000
) (
  input  logic             req_valid,
  input  logic [PIN_W-1:0] req_pin,
  input  logic [63:0]      entry,
  output logic             deliver,
  output msi_msg_t         msg
);
  localparam logic [PIN_W:0] PIN_LIMIT = NUM_PINS[PIN_W:0];

  logic in_range;
  logic unused_bits;

  assign unused_bits = ^{entry[48:17], entry[14:12]};

  always_comb begin
    in_range = ({1'b0, req_pin} < PIN_LIMIT);
    deliver  = req_valid && in_range && !entry[BIT_MASK]
               && !entry[BIT_DMODE] && !entry[BIT_TRIG];
    msg.addr = MSI_BASE | {12'h000, entry[63:56], entry[55:49], 5'b00000};
    msg.data = {16'h0000, entry[BIT_TRIG], 1'b0, 2'b00, 1'b0,
                entry[10:8], entry[7:0]};
  end
endmodule

// File: rtl/msi_out_stage.sv
module msi_out_stage
  import msi_fmt_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     in_valid,
  input  msi_msg_t in_msg,
  input  logic     out_ready,
  output logic     out_valid,
  output msi_msg_t out_msg,
  output logic     ovf
);
  logic     hold_v;
  msi_msg_t hold_m;
  logic     out_free;

  assign out_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      hold_v    <= 1'b0;
      ovf       <= 1'b0;
      out_msg   <= '0;
      hold_m    <= '0;
    end else begin
      ovf <= 1'b0;
      if (out_free) begin
        if (hold_v) begin
          out_valid <= 1'b1;
          out_msg   <= hold_m;
          hold_v    <= in_valid;
          if (in_valid) hold_m <= in_msg;
        end else begin
          out_valid <= in_valid;
          if (in_valid) out_msg <= in_msg;
        end
      end else if (in_valid) begin
        if (!hold_v) begin
          hold_v <= 1'b1;
          hold_m <= in_msg;
        end else begin
          ovf <= 1'b1;
        end
      end
    end
  end

  // R8: a stalled message does not move
  p_stall_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_msg)));

  // R10: overflow only follows a cycle with both slots busy and no acceptance
  p_ovf_cause_r10: assert property (@(posedge clk) disable iff (rst)
    ovf |-> $past(out_valid && !out_ready && hold_v && in_valid));

  // R9: the holding slot is only used behind a waiting message
  p_hold_behind_r9: assert property (@(posedge clk) disable iff (rst)
    hold_v |-> out_valid);
endmodule

// File: rtl/irq_msi_fmt.sv
module irq_msi_fmt
  import msi_fmt_pkg::*;
#(
  parameter int          NUM_PINS = 24,
  parameter int          PIN_W    = 5,
  parameter logic [31:0] MSI_BASE = 32'hFEE0_0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [PIN_W-1:0] req_pin,
  output logic [PIN_W-1:0] tbl_pin,
  input  logic [63:0]      tbl_entry,
  output logic             msg_valid,
  input  logic             msg_ready,
  output logic [31:0]      msg_addr,
  output logic [31:0]      msg_data,
  output logic             ovf
);
  logic     dec_ok;
  msi_msg_t dec_msg;
  msi_msg_t q_msg;

  assign tbl_pin = req_pin;

  msi_entry_decode #(
    .NUM_PINS(NUM_PINS), .PIN_W(PIN_W), .MSI_BASE(MSI_BASE)
  ) u_dec (
    .req_valid(req_valid), .req_pin(req_pin), .entry(tbl_entry),
    .deliver(dec_ok), .msg(dec_msg)
  );

  msi_out_stage u_out (
    .clk(clk), .rst(rst), .in_valid(dec_ok), .in_msg(dec_msg),
    .out_ready(msg_ready), .out_valid(msg_valid), .out_msg(q_msg), .ovf(ovf)
  );

  assign msg_addr = q_msg.addr;
  assign msg_data = q_msg.data;

  // R5: the address always carries the fixed base window
  p_addr_base_r5: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> (msg_addr[31:20] == MSI_BASE[31:20] && msg_addr[4:0] == 5'd0));

  // R6: reserved and level-assert data bits stay clear
  p_data_zero_r6: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> (msg_data[31:11] == 21'd0));
endmodule

// File: tb/tb_irq_msi_fmt.sv
module tb_irq_msi_fmt;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [4:0]  req_pin = 5'd0;
  logic [4:0]  tbl_pin;
  logic [63:0] tbl_entry;
  logic        msg_valid;
  logic        msg_ready = 1'b0;
  logic [31:0] msg_addr;
  logic [31:0] msg_data;
  logic        ovf;

  logic [63:0] tbl [0:23];
  logic [63:0] q [$];
  logic        exp_ovf = 1'b0;
  int          checks = 0;
  int          fails  = 0;
  string       tag = "R11";

  always #2 clk = ~clk;

  assign tbl_entry = (tbl_pin < 5'd24) ? tbl[tbl_pin] : 64'h0200_0000_0000_0031;

  irq_msi_fmt dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_pin(req_pin),
    .tbl_pin(tbl_pin), .tbl_entry(tbl_entry), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data), .ovf(ovf)
  );

  function automatic logic [63:0] mk(int vec, int dm, int logical, int level,
                                     int mask, int ext, int dest);
    longint v;
    v = vec + dm * 256 + logical * 2048 + level * 32768 + mask * 65536;
    v = v + (longint'(ext) << 49) + (longint'(dest) << 56);
    return 64'(v);
  endfunction

  function automatic logic [63:0] expect_msg(logic [63:0] e);
    int unsigned a, d;
    a = 32'hFEE0_0000 + int'(e[63:56]) * 4096 + int'(e[55:49]) * 32;
    d = int'(e[7:0]) + int'(e[10:8]) * 256;
    return {a, d};
  endfunction

  // reference model: two-entry queue
  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      exp_ovf <= 1'b0;
    end else begin
      logic [63:0] e;
      logic ok;
      exp_ovf <= 1'b0;
      if (q.size() > 0 && msg_ready) void'(q.pop_front());
      e  = tbl_entry;
      ok = req_valid && (req_pin < 5'd24) && !e[16] && !e[11] && !e[15];
      if (ok) begin
        if (q.size() < 2) q.push_back(expect_msg(e));
        else exp_ovf <= 1'b1;
      end
    end
  end

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk("valid", 64'(msg_valid), 64'(q.size() > 0));
      chk("ovf R10", 64'(ovf), 64'(exp_ovf));
      chk("tbl_pin R13", 64'(tbl_pin), 64'(req_pin));
      if (q.size() > 0 && msg_valid) begin
        chk("addr R5", 64'(msg_addr), 64'(q[0][63:32]));
        chk("data R6", 64'(msg_data), 64'(q[0][31:0]));
      end
    end
  end

  task automatic req(int pin);
    @(posedge clk); #1;
    req_valid = 1'b1; req_pin = 5'(pin);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 24; i++) tbl[i] = mk(16 + i, 0, 0, 0, 0, 0, i);
    tbl[4] = mk(8'h24, 0, 0, 0, 0, 0, 2);
    tbl[7] = mk(8'h77, 4, 0, 0, 0, 7'h55, 8'hA5);
    tbl[1] = mk(8'h31, 0, 0, 0, 1, 0, 3);
    tbl[2] = mk(8'h32, 0, 1, 0, 0, 0, 3);
    tbl[3] = mk(8'h33, 0, 0, 1, 0, 0, 3);
    tbl[5] = mk(8'hFE, 7, 0, 0, 0, 7'h7F, 8'hFF);
    idle(3);
    #1 rst = 1'b0;
    @(negedge clk);
    tag = "R11";
    chk("reset valid", 64'(msg_valid), 64'd0);
    chk("reset ovf", 64'(ovf), 64'd0);

    tag = "R12";
    msg_ready = 1'b1;
    req(4);
    @(negedge clk);
    chk("example addr", 64'(msg_addr), 64'hFEE0_2000);
    chk("example data", 64'(msg_data), 64'h0000_0024);
    idle(2);

    tag = "R7"; req(7); idle(2);
    tag = "R5"; req(5); idle(2);
    tag = "R2"; req(1); idle(2);
    tag = "R3"; req(2); idle(2);
    tag = "R4"; req(3); idle(2);
    tag = "R1"; req(24); req(31); idle(2);

    tag = "R8";
    msg_ready = 1'b0;
    req(4); idle(4);
    tag = "R9"; req(7); idle(3);
    tag = "R10"; req(5); idle(3);
    msg_ready = 1'b1; idle(4);

    tag = "R9";
    msg_ready = 1'b0;
    req(6); req(8); idle(1);
    msg_ready = 1'b1;
    req(9); idle(5);

    tag = "R7";
    for (int i = 10; i < 16; i++) req(i);
    idle(4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule